// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block arbitrates among eight interrupt request lines on behalf of a processor. Software reaches it through a register port with two addresses, selected by a single address bit. It programs the controller with a short sequence of setup words: a start word, a base vector type, a cascade word and an optional mode word. After that sequence, software writes a mask and issues commands. A request is captured on a rising edge of its line. The highest-priority unmasked request that outranks everything already in service raises the interrupt output.

The processor answers with a one-cycle acknowledge pulse. On the following cycle the controller presents an 8-bit vector type, which is the base type with its line index added. At the same time the winning line moves from the request register into the in-service register. An end-of-interrupt command retires the highest-priority in-service line. If the request has vanished by the time of the acknowledge, the controller returns the vector of the lowest-priority line and sets no in-service bit, so the handler can tell a false request from a real one by reading the in-service register back.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, and whenever a start word is written, the request register, the in-service register and the mask are cleared, and port 0 reads return the request register. The start word is a port 0 write with bit 4 set. Port 1 reads return the mask.
- R2: The setup sequence is a start word followed by one, two or three port 1 words: the base, then the cascade word (only when start bit 1 is 0), then the mode word (only when start bit 0 is 1). The next port 1 write after the sequence loads the mask.
- R3: The acknowledged vector type is the base with its low three bits forced to zero, plus the line index. For example, base 96 with line 3 gives 99, and base 0xC5 with line 0 gives 192.
- R4: A set mask bit stops that line from raising the interrupt output. The line's request bit still latches and can be read on port 0.
- R5: Once setup is complete, a port 0 write of 0x0B makes port 0 reads return the in-service register, and a port 0 write of 0x0A makes them return the request register.
- R6: A port 0 write of 0x20 clears the lowest-index set bit of the in-service register. With the in-service register empty it has no effect.
- R7: Priority is fixed, with line 0 highest. The interrupt output is high only when setup is complete and some unmasked request has a lower index than every in-service bit.
- R8: A request bit sets on a low-to-high transition of its input and clears when the input is low. An input that stays high does not request again after it has been acknowledged.
- R9: An acknowledge pulse produces a valid flag and the vector type on the next cycle, for exactly that one cycle. If a request was winning, its request bit clears and its in-service bit sets.
- R10: An acknowledge while the interrupt output is low returns the base plus 7 and leaves the in-service register unchanged. A real line 7 acknowledge reads back as in-service value 0x80.
- R11: The slave flag rises alongside a valid vector when the acknowledged line's bit is set in the cascade word and cascade mode is active. It stays low for false requests and in single mode.
- R12: The interrupt output stays low until the setup sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register port select (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Interrupt request lines, line 0 highest priority |
| int_req | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| ack_valid | output | 1 | Vector type valid, one cycle after the acknowledge |
| ack_type | output | 8 | Vector type of the acknowledged line |
| ack_slave | output | 1 | Acknowledged line has a cascaded slave |

## Verification
The bench builds the controller with eight lines in the master role, which is the configuration in which the cascade word acts as a per-line slave map. That choice brings the slave flag within reach on line 7, and it makes line 7 the target of false requests. Both cascade and single setup paths are exercised, with and without the mode word. Together these cover all three sequence lengths, base alignment from an unaligned value, and nesting two in-service levels deep.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VEC_W    = 8;
  localparam int NONE_IDX = 32;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;

  // Index of the lowest set bit, NONE_IDX when empty.
  function automatic int first_set(input logic [31:0] v);
    int r;
    r = NONE_IDX;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Drop the low index bits so a line index can be merged in.
  function automatic logic [VEC_W-1:0] align_base(input logic [VEC_W-1:0] raw,
                                                  input int idx_w);
    return (raw >> idx_w) << idx_w;
  endfunction

  function automatic logic [VEC_W-1:0] line_type(input logic [VEC_W-1:0] base,
                                                 input int idx);
    return base | VEC_W'(idx);
  endfunction
endpackage

// File: rtl/vic_cfg.sv
module vic_cfg import vic_pkg::*; #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [VEC_W-1:0]   wdata,
  output logic               ready,
  output logic [VEC_W-1:0]   base,
  output logic [N_LINES-1:0] casc,
  output logic               single,
  output logic [N_LINES-1:0] mask,
  output logic               rd_isr,
  output logic               init_evt,
  output logic               eoi_evt
);
  localparam int IDX_W = $clog2(N_LINES);

  cfg_state_e state;
  logic       need_mode;
  logic       wr0, wr1, ocw_sel;

  assign wr0      = wr_en && !addr;
  assign wr1      = wr_en && addr;
  assign ready    = (state == CFG_RUN);
  assign init_evt = wr0 && wdata[4];
  assign ocw_sel  = wr0 && !wdata[4] && wdata[3] && ready;
  assign eoi_evt  = wr0 && !wdata[4] && !wdata[3] && ready && (wdata[7:5] == 3'b001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CFG_IDLE;
      base      <= '0;
      casc      <= '0;
      single    <= 1'b0;
      need_mode <= 1'b0;
      mask      <= '0;
      rd_isr    <= 1'b0;
    end else if (init_evt) begin
      state     <= CFG_BASE;
      need_mode <= wdata[0];
      single    <= wdata[1];
      mask      <= '0;
      rd_isr    <= 1'b0;
    end else if (wr1) begin
      case (state)
        CFG_BASE: begin
          base <= align_base(wdata, IDX_W);
          if (!single)        state <= CFG_CASC;
          else if (need_mode) state <= CFG_MODE;
          else                state <= CFG_RUN;
        end
        CFG_CASC: begin
          casc  <= wdata[N_LINES-1:0];
          state <= need_mode ? CFG_MODE : CFG_RUN;
        end
        CFG_MODE: state <= CFG_RUN;
        CFG_RUN:  mask  <= wdata[N_LINES-1:0];
        default:  ;
      endcase
    end else if (ocw_sel && wdata[1]) begin
      rd_isr <= wdata[0];
    end
  end
endmodule

// File: rtl/vic_edge.sv
module vic_edge #(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               hold_clr,
  input  logic [N_LINES-1:0] ack_clr,
  output logic [N_LINES-1:0] irr
);
  logic [N_LINES-1:0] prev;
  logic [N_LINES-1:0] rise;

  assign rise = irq_in & ~prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      if (hold_clr) irr <= '0;
      else          irr <= (irr | rise) & irq_in & ~ack_clr;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio import vic_pkg::*; #(
  parameter int N_LINES = 8
) (
  input  logic               ready,
  input  logic [N_LINES-1:0] irr,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] isr,
  output logic               int_req,
  output logic [$clog2(N_LINES)-1:0] win_idx,
  output logic [N_LINES-1:0] win_hot,
  output logic [N_LINES-1:0] srv_hot
);
  localparam int IDX_W = $clog2(N_LINES);

  int p_idx;
  int s_idx;

  always_comb begin
    p_idx = first_set(32'(irr & ~mask));
    s_idx = first_set(32'(isr));
  end

  assign int_req = ready && (p_idx != NONE_IDX) && (p_idx < s_idx);
  assign win_idx = p_idx[IDX_W-1:0];

  for (genvar g = 0; g < N_LINES; g++) begin : g_hot
    assign win_hot[g] = (p_idx == g);
    assign srv_hot[g] = (s_idx == g);
  end
endmodule

// File: rtl/vic_svc.sv
module vic_svc import vic_pkg::*; #(
  parameter int N_LINES    = 8,
  parameter bit SLAVE_ROLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack,
  input  logic               grant,
  input  logic [$clog2(N_LINES)-1:0] win_idx,
  input  logic [N_LINES-1:0] win_hot,
  input  logic [N_LINES-1:0] srv_hot,
  input  logic               eoi_evt,
  input  logic               hold_clr,
  input  logic [VEC_W-1:0]   base,
  input  logic [N_LINES-1:0] casc,
  input  logic               single,
  output logic [N_LINES-1:0] isr,
  output logic               ack_valid,
  output logic [VEC_W-1:0]   ack_type,
  output logic               ack_slave
);
  logic [N_LINES-1:0] set_hot, clr_hot;
  int                 sel_idx;
  logic               slave_hit;

  assign set_hot   = grant ? win_hot : '0;
  assign clr_hot   = eoi_evt ? srv_hot : '0;
  assign sel_idx   = grant ? int'(win_idx) : N_LINES - 1;
  assign slave_hit = !SLAVE_ROLE && grant && !single && casc[win_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr       <= '0;
      ack_valid <= 1'b0;
      ack_type  <= '0;
      ack_slave <= 1'b0;
    end else begin
      isr       <= hold_clr ? '0 : ((isr & ~clr_hot) | set_hot);
      ack_valid <= ack;
      ack_type  <= ack ? line_type(base, sel_idx) : '0;
      ack_slave <= slave_hit;
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl import vic_pkg::*; #(
  parameter int N_LINES    = 8,
  parameter bit SLAVE_ROLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               int_req,
  input  logic               ack,
  output logic               ack_valid,
  output logic [7:0]         ack_type,
  output logic               ack_slave
);
  localparam int IDX_W = $clog2(N_LINES);

  logic               ready, single, rd_isr, init_evt, eoi_evt;
  logic               hold_clr, grant;
  logic [VEC_W-1:0]   base;
  logic [N_LINES-1:0] casc, mask, irr, isr;
  logic [N_LINES-1:0] win_hot, srv_hot, grant_hot;
  logic [IDX_W-1:0]   win_idx;

  assign hold_clr  = !ready || init_evt;
  assign grant     = ack && int_req;
  assign grant_hot = grant ? win_hot : '0;
  assign rdata     = addr ? VEC_W'(mask) : VEC_W'(rd_isr ? isr : irr);

  vic_cfg #(.N_LINES(N_LINES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ready(ready), .base(base), .casc(casc), .single(single), .mask(mask),
    .rd_isr(rd_isr), .init_evt(init_evt), .eoi_evt(eoi_evt)
  );

  vic_edge #(.N_LINES(N_LINES)) u_edge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .hold_clr(hold_clr),
    .ack_clr(grant_hot), .irr(irr)
  );

  vic_prio #(.N_LINES(N_LINES)) u_prio (
    .ready(ready), .irr(irr), .mask(mask), .isr(isr), .int_req(int_req),
    .win_idx(win_idx), .win_hot(win_hot), .srv_hot(srv_hot)
  );

  vic_svc #(.N_LINES(N_LINES), .SLAVE_ROLE(SLAVE_ROLE)) u_svc (
    .clk(clk), .rst_n(rst_n), .ack(ack), .grant(grant), .win_idx(win_idx),
    .win_hot(win_hot), .srv_hot(srv_hot), .eoi_evt(eoi_evt), .hold_clr(hold_clr),
    .base(base), .casc(casc), .single(single), .isr(isr),
    .ack_valid(ack_valid), .ack_type(ack_type), .ack_slave(ack_slave)
  );
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ready,
  input logic               init_evt,
  input logic               eoi_evt,
  input logic               ack,
  input logic               int_req,
  input logic               ack_valid,
  input logic [7:0]         ack_type,
  input logic               ack_slave,
  input logic [N_LINES-1:0] irq_in,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] isr,
  input logic [N_LINES-1:0] mask
);
  localparam int IDX_W = $clog2(N_LINES);
  logic [N_LINES-1:0] below_srv;
  assign below_srv = (isr & (~isr + 1'b1)) - 1'b1;

  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (irr == '0 && isr == '0 && mask == '0)); // R1
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~mask) != '0)); // R4
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_evt && !ack && isr != '0) |=> ($countones(isr) + 1 == $countones($past(isr)))); // R6
  AST_PRIO_ABOVE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> ((irr & ~mask & below_srv) != '0)); // R7
  AST_LOW_INPUT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irq_in)) == '0)); // R8
  AST_ACK_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> ack_valid); // R9
  AST_GRANT_ADDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req && !eoi_evt && !init_evt) |=> ($countones(isr) == $countones($past(isr)) + 1)); // R9
  AST_SPURIOUS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !int_req && !eoi_evt && !init_evt) |=>
      (ack_type[IDX_W-1:0] == {IDX_W{1'b1}} && isr == $past(isr))); // R10
  AST_SLAVE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ack_slave |-> ack_valid); // R11
  AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_req); // R12
endmodule

bind vic_ctrl vic_chk #(.N_LINES(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .init_evt(init_evt), .eoi_evt(eoi_evt),
  .ack(ack), .int_req(int_req), .ack_valid(ack_valid), .ack_type(ack_type),
  .ack_slave(ack_slave), .irq_in(irq_in), .irr(irr), .isr(isr), .mask(mask)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [N-1:0] irq = '0;
  logic [7:0] rdata, ack_type;
  logic       int_req, ack_valid, ack_slave;

  always #4 clk = ~clk;

  vic_ctrl #(.N_LINES(N), .SLAVE_ROLE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_in(irq), .int_req(int_req), .ack(ack), .ack_valid(ack_valid),
    .ack_type(ack_type), .ack_slave(ack_slave)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model.
  bit [7:0] m_irr, m_isr, m_mask, m_casc, m_prev;
  int       m_st, m_base, m_at;
  bit       m_single, m_ic4, m_rsel, m_av, m_as;
  int       w, s;
  bit       rdy, live, ini, eoi;

  function automatic int lowest(input bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic bit m_int();
    int pw, ps;
    pw = lowest(m_irr & ~m_mask);
    ps = lowest(m_isr);
    return (m_st == 4) && pw < 8 && pw < ps;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 0; m_casc = 0; m_prev = 0;
      m_st = 0; m_base = 0; m_at = 0; m_single = 0; m_ic4 = 0; m_rsel = 0;
      m_av = 0; m_as = 0;
    end else begin
      w    = lowest(m_irr & ~m_mask);
      s    = lowest(m_isr);
      rdy  = (m_st == 4);
      live = rdy && w < 8 && w < s;
      ini  = wr_en && !addr && wdata[4];
      eoi  = wr_en && !addr && rdy && !wdata[4] && !wdata[3] && wdata[7:5] == 3'd1;
      m_av = ack;
      m_at = ack ? m_base + (live ? w : 7) : 0;
      m_as = ack && live && !m_single && m_casc[live ? w : 0];
      if (!rdy || ini) begin
        m_isr = 0; m_irr = 0;
      end else begin
        if (eoi && s < 8) m_isr[s] = 1'b0;
        if (ack && live) m_isr[w] = 1'b1;
        for (int i = 0; i < 8; i++) begin
          if (irq[i] && !m_prev[i]) m_irr[i] = 1'b1;
          if (!irq[i]) m_irr[i] = 1'b0;
        end
        if (ack && live) m_irr[w] = 1'b0;
      end
      m_prev = irq;
      if (ini) begin
        m_st = 1; m_ic4 = wdata[0]; m_single = wdata[1]; m_mask = 0; m_rsel = 0;
      end else if (wr_en && addr) begin
        case (m_st)
          1: begin
            m_base = (int'(wdata) / 8) * 8;
            m_st = !m_single ? 2 : (m_ic4 ? 3 : 4);
          end
          2: begin m_casc = wdata; m_st = m_ic4 ? 3 : 4; end
          3: m_st = 4;
          4: m_mask = wdata;
          default: ;
        endcase
      end else if (wr_en && !addr && rdy && wdata[3] && wdata[1]) begin
        m_rsel = wdata[0];
      end
    end
  end

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 int_req vs model", int'(int_req), int'(m_int()));
      check("R9 ack_valid vs model", int'(ack_valid), int'(m_av));
      check("R3 ack_type vs model", int'(ack_type), m_at);
      check("R11 ack_slave vs model", int'(ack_slave), int'(m_as));
      check("R5 rdata vs model", int'(rdata),
            int'(addr ? m_mask : (m_rsel ? m_isr : m_irr)));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input bit a, input bit [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    look();
    check("R1 reset int_req", int'(int_req), 0);
    check("R1 reset irr read", int'(rdata), 0);
    check("R1 reset ack_valid", int'(ack_valid), 0);
    addr = 1'b1; look();
    check("R1 reset mask read", int'(rdata), 0);

    // Request before setup completes
    irq[2] = 1'b1; tick(); tick(); look();
    check("R12 no int before setup", int'(int_req), 0);

    // Cascade setup with mode word
    wr(0, 8'h11); wr(1, 8'd96); wr(1, 8'h80); wr(1, 8'h01);
    addr = 1'b1; look();
    check("R2 mask clear after setup", int'(rdata), 0);
    check("R8 steady high line not a request", int'(int_req), 0);
    wr(1, 8'hF0); look();
    check("R4 mask readback", int'(rdata), 8'hF0);
    wr(1, 8'h00);
    irq[2] = 1'b0; tick();

    irq[3] = 1'b1; tick(); look();
    check("R8 rising edge raises int", int'(int_req), 1);
    addr = 1'b0; look();
    check("R8 request bit latched", int'(rdata), 8'h08);
    pulse_ack(); look();
    check("R9 valid after ack", int'(ack_valid), 1);
    check("R3 type base 96 line 3", int'(ack_type), 99);
    tick(); look();
    check("R9 valid lasts one cycle", int'(ack_valid), 0);
    wr(0, 8'h0B); look();
    check("R5 in-service readback", int'(rdata), 8'h08);

    irq[5] = 1'b1; tick(); look();
    check("R7 lower priority held off", int'(int_req), 0);
    irq[1] = 1'b1; tick(); look();
    check("R7 higher priority nests", int'(int_req), 1);
    pulse_ack(); look();
    check("R3 type line 1", int'(ack_type), 97);
    tick(); look();
    check("R5 two lines in service", int'(rdata), 8'h0A);
    wr(0, 8'h20); look();
    check("R6 eoi clears top line", int'(rdata), 8'h08);
    wr(0, 8'h20); look();
    check("R6 second eoi", int'(rdata), 8'h00);
    check("R7 pending line 5 now wins", int'(int_req), 1);
    pulse_ack(); look();
    check("R3 type line 5", int'(ack_type), 101);
    wr(0, 8'h20);
    wr(0, 8'h0A); look();
    check("R8 held lines do not rerequest", int'(rdata), 0);

    // Mask
    wr(1, 8'h01);
    irq[0] = 1'b1; tick(); look();
    check("R4 masked line silent", int'(int_req), 0);
    check("R4 masked request still latched", int'(rdata), 8'h01);
    wr(1, 8'h00); look();
    check("R4 unmask raises int", int'(int_req), 1);
    pulse_ack(); look();
    check("R3 type line 0", int'(ack_type), 96);
    wr(0, 8'h20);

    // Simultaneous requests
    irq = '0; tick();
    irq[2] = 1'b1; irq[6] = 1'b1; tick();
    pulse_ack(); look();
    check("R7 line 2 beats line 6", int'(ack_type), 98);
    wr(0, 8'h20);
    pulse_ack(); look();
    check("R7 line 6 follows", int'(ack_type), 102);
    wr(0, 8'h20);

    // False request
    irq = '0; tick();
    irq[4] = 1'b1; tick(); look();
    check("R8 line 4 raises int", int'(int_req), 1);
    irq[4] = 1'b0; tick(); look();
    check("R8 dropped line clears", int'(int_req), 0);
    pulse_ack(); look();
    check("R10 false request type", int'(ack_type), 103);
    check("R11 no slave on false request", int'(ack_slave), 0);
    wr(0, 8'h0B); look();
    check("R10 in-service untouched", int'(rdata), 0);

    // Real line 7 with slave
    irq[7] = 1'b1; tick();
    pulse_ack(); look();
    check("R10 real line 7 type", int'(ack_type), 103);
    check("R11 slave flag on line 7", int'(ack_slave), 1);
    tick(); look();
    check("R10 real line 7 in service", int'(rdata), 8'h80);
    wr(0, 8'h20); look();
    check("R6 eoi line 7", int'(rdata), 0);
    wr(0, 8'h20); look();
    check("R6 eoi with empty service", int'(rdata), 0);

    // Single mode with mode word
    irq = '0;
    wr(0, 8'h13); look();
    check("R1 start word resets readback", int'(rdata), 0);
    wr(1, 8'd104); wr(1, 8'h01); wr(1, 8'h00);
    irq[6] = 1'b1; tick();
    pulse_ack(); look();
    check("R2 single with mode type", int'(ack_type), 110);
    check("R11 no slave in single mode", int'(ack_slave), 0);
    wr(0, 8'h20);

    // Single mode without mode word, unaligned base
    wr(0, 8'h12); wr(1, 8'hC5); wr(1, 8'h3C);
    addr = 1'b1; look();
    check("R2 short sequence then mask", int'(rdata), 8'h3C);
    irq[6] = 1'b0; tick();
    irq[0] = 1'b1; tick();
    pulse_ack(); look();
    check("R3 base aligned", int'(ack_type), 192);
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule